// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage in-order pipeline gets past data dependencies. It compares the register numbers read in the decode and execute stages against the destinations of the instructions further down the pipe. From these comparisons it produces operand bypass selects for the execute-stage ALU inputs, and bypass enables for the decode-stage equality compare that resolves branches early.

When a bypass cannot supply a value in time, the unit holds the fetch and decode registers and clears the execute register so that a bubble enters the pipe. There are three such cases: a load followed at once by a reader, a branch that needs an ALU result still in execute, and a branch that needs load data still in the memory stage. An external interrupt request clears the decode and execute registers so that the exception vector can be fetched cleanly.

All outputs are combinational functions of the current inputs. They drive pipeline flip-flops that have an enable and a synchronous clear.

Top module: `hazard_unit`

## Requirements
- R1: An execute operand select (`fwdAE`, `fwdBE`) is 2'b10 (memory-stage result) when the memory stage writes a nonzero register equal to that operand's source register. This case wins over any writeback match.
- R2: An execute operand select is 2'b01 (writeback result) when there is no memory-stage match and the writeback stage writes a nonzero register equal to that source.
- R3: An execute operand select is 2'b00 (register file value) when neither later stage matches. Register zero, and a stage whose write enable is low, never match.
- R4: A decode compare forward (`fwdAD`, `fwdBD`) is 1 exactly when the memory stage writes a nonzero register equal to that decode source register.
- R5: A load in execute (`memToRegE` high) whose nonzero destination equals either decode source register raises `stallF`, `stallD` and `flushE`, and leaves `flushD` low unless an interrupt is pending.
- R6: A branch in decode raises `stallF`, `stallD` and `flushE` when the execute stage writes a nonzero register that the branch reads.
- R7: A branch in decode raises `stallF`, `stallD` and `flushE` when the memory stage holds a load to a nonzero register that the branch reads.
- R8: A destination of register zero never causes a stall. A non-branch instruction never stalls on execute ALU results or on memory-stage loads.
- R9: `intReq` high raises both `flushD` and `flushE`. `flushD` is high only when `intReq` is high.
- R10: With no dependency and no interrupt, all four stall and flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcAD | input | 5 | First source register of the decode instruction |
| srcBD | input | 5 | Second source register of the decode instruction |
| srcAE | input | 5 | First source register of the execute instruction |
| srcBE | input | 5 | Second source register of the execute instruction |
| dstE | input | 5 | Destination register in execute |
| dstM | input | 5 | Destination register in memory |
| dstW | input | 5 | Destination register in writeback |
| wrEnE | input | 1 | Execute instruction writes a register |
| wrEnM | input | 1 | Memory instruction writes a register |
| wrEnW | input | 1 | Writeback instruction writes a register |
| memToRegE | input | 1 | Execute instruction is a load |
| memToRegM | input | 1 | Memory instruction is a load |
| branchD | input | 1 | Decode instruction is a branch |
| intReq | input | 1 | External interrupt request |
| stallF | output | 1 | Hold the fetch register |
| stallD | output | 1 | Hold the decode register |
| flushD | output | 1 | Clear the decode register |
| flushE | output | 1 | Clear the execute register |
| fwdAE | output | 2 | Execute operand A select: 00 register file, 01 writeback, 10 memory |
| fwdBE | output | 2 | Execute operand B select, same encoding |
| fwdAD | output | 1 | Decode compare operand A from memory stage |
| fwdBD | output | 1 | Decode compare operand B from memory stage |

## Verification
The unit holds no state, so any fault in its comparison or priority logic shows at the ports in the same cycle as the input pattern that triggers it. A broken priority appears as a select of 01 where 10 is due whenever both later stages write the same register. A missing zero guard shows as a spurious stall or bypass when a destination is register zero. Small random register numbers make matches, overlaps and zero destinations frequent, so every compare path is hit many times within a few thousand vectors.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int REG_BITS = 5;
  typedef logic [REG_BITS-1:0] regIdx_t;

  typedef enum logic [1:0] {
    FWD_REG = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_t;

  // dependency strobes passed from the compare logic to the control
  typedef struct packed {
    logic loadUse;
    logic brOnAlu;
    logic brOnLoad;
  } depStrobes_t;
endpackage

// File: rtl/hzd_match.sv
module hzd_match
  import hzd_pkg::*;
#(
  parameter int NUM_E_SRC = 2,
  parameter int NUM_D_SRC = 2
) (
  input  regIdx_t     srcD [NUM_D_SRC],
  input  regIdx_t     srcE [NUM_E_SRC],
  input  regIdx_t     dstE,
  input  regIdx_t     dstM,
  input  regIdx_t     dstW,
  input  logic        wrEnE,
  input  logic        wrEnM,
  input  logic        wrEnW,
  input  logic        memToRegE,
  input  logic        memToRegM,
  input  logic        branchD,
  output fwdSel_t     fwdE [NUM_E_SRC],
  output logic        fwdD [NUM_D_SRC],
  output depStrobes_t deps
);
  localparam regIdx_t ZERO_REG = '0;

  logic liveE, liveM, liveW, loadE, loadM;
  assign liveE = wrEnE && (dstE != ZERO_REG);
  assign liveM = wrEnM && (dstM != ZERO_REG);
  assign liveW = wrEnW && (dstW != ZERO_REG);
  assign loadE = memToRegE && (dstE != ZERO_REG);
  assign loadM = memToRegM && (dstM != ZERO_REG);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_E_SRC; gi++) begin : g_exec
      always_comb begin
        if (liveM && (dstM == srcE[gi]))      fwdE[gi] = FWD_MEM;
        else if (liveW && (dstW == srcE[gi])) fwdE[gi] = FWD_WB;
        else                                  fwdE[gi] = FWD_REG;
      end

      always_comb begin
        p_zero_src_no_fwd_r3: assert (srcE[gi] != ZERO_REG || fwdE[gi] == FWD_REG)
          else $error("register zero was bypassed");
        p_wb_only_below_mem_r2: assert (fwdE[gi] != FWD_WB ||
                                        !(wrEnM && dstM == srcE[gi] && dstM != ZERO_REG))
          else $error("writeback chosen over memory stage");
      end
    end

    for (gi = 0; gi < NUM_D_SRC; gi++) begin : g_dec
      assign fwdD[gi] = liveM && (dstM == srcD[gi]);
    end
  endgenerate

  logic readsE, readsLoadE, readsLoadM;
  always_comb begin
    readsE = 1'b0;
    readsLoadE = 1'b0;
    readsLoadM = 1'b0;
    for (int k = 0; k < NUM_D_SRC; k++) begin
      readsE     |= liveE && (dstE == srcD[k]);
      readsLoadE |= loadE && (dstE == srcD[k]);
      readsLoadM |= loadM && (dstM == srcD[k]);
    end
  end

  assign deps.loadUse  = readsLoadE;
  assign deps.brOnAlu  = branchD && readsE;
  assign deps.brOnLoad = branchD && readsLoadM;

  always_comb begin
    p_no_branch_dep_r8: assert (branchD || !(deps.brOnAlu || deps.brOnLoad))
      else $error("branch dependency without a branch");
  end
endmodule

// File: rtl/hzd_control.sv
module hzd_control
  import hzd_pkg::*;
(
  input  depStrobes_t deps,
  input  logic        intReq,
  output logic        stallF,
  output logic        stallD,
  output logic        flushD,
  output logic        flushE
);
  logic holdFront;
  assign holdFront = deps.loadUse | deps.brOnAlu | deps.brOnLoad;

  assign stallF = holdFront;
  assign stallD = holdFront;
  assign flushD = intReq;
  assign flushE = holdFront | intReq;

  always_comb begin
    p_int_clears_both_r9: assert (!intReq || (flushD && flushE))
      else $error("interrupt did not clear decode and execute");
    p_stall_inserts_bubble_r5: assert (!stallD || (flushE && stallF))
      else $error("stall without bubble");
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hzd_pkg::*;
(
  input  logic [4:0] srcAD,
  input  logic [4:0] srcBD,
  input  logic [4:0] srcAE,
  input  logic [4:0] srcBE,
  input  logic [4:0] dstE,
  input  logic [4:0] dstM,
  input  logic [4:0] dstW,
  input  logic       wrEnE,
  input  logic       wrEnM,
  input  logic       wrEnW,
  input  logic       memToRegE,
  input  logic       memToRegM,
  input  logic       branchD,
  input  logic       intReq,
  output logic       stallF,
  output logic       stallD,
  output logic       flushD,
  output logic       flushE,
  output logic [1:0] fwdAE,
  output logic [1:0] fwdBE,
  output logic       fwdAD,
  output logic       fwdBD
);
  regIdx_t     srcD [2];
  regIdx_t     srcE [2];
  fwdSel_t     fwdE [2];
  logic        fwdD [2];
  depStrobes_t deps;

  assign srcD[0] = srcAD;
  assign srcD[1] = srcBD;
  assign srcE[0] = srcAE;
  assign srcE[1] = srcBE;

  hzd_match #(.NUM_E_SRC(2), .NUM_D_SRC(2)) u_match (
    .srcD(srcD), .srcE(srcE), .dstE(dstE), .dstM(dstM), .dstW(dstW),
    .wrEnE(wrEnE), .wrEnM(wrEnM), .wrEnW(wrEnW),
    .memToRegE(memToRegE), .memToRegM(memToRegM), .branchD(branchD),
    .fwdE(fwdE), .fwdD(fwdD), .deps(deps)
  );

  hzd_control u_ctrl (
    .deps(deps), .intReq(intReq),
    .stallF(stallF), .stallD(stallD), .flushD(flushD), .flushE(flushE)
  );

  assign fwdAE = fwdE[0];
  assign fwdBE = fwdE[1];
  assign fwdAD = fwdD[0];
  assign fwdBD = fwdD[1];

  always_comb begin
    p_quiet_without_cause_r8: assert (memToRegE || branchD || !stallD)
      else $error("stall without load or branch");
  end
endmodule

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] srcAD, srcBD, srcAE, srcBE, dstE, dstM, dstW;
  logic wrEnE, wrEnM, wrEnW, memToRegE, memToRegM, branchD, intReq;
  logic stallF, stallD, flushD, flushE, fwdAD, fwdBD;
  logic [1:0] fwdAE, fwdBE;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  hazard_unit u0 (.*);

  function automatic logic [1:0] expFwdE(input logic [4:0] s);
    if (wrEnM && dstM != 0 && dstM == s) return 2'b10;
    if (wrEnW && dstW != 0 && dstW == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expFwdD(input logic [4:0] s);
    return (s != 0) && wrEnM && (dstM == s);
  endfunction

  function automatic logic expStall();
    logic rdE, rdM;
    rdE = (dstE != 0) && (dstE == srcAD || dstE == srcBD);
    rdM = (dstM != 0) && (dstM == srcAD || dstM == srcBD);
    return (memToRegE && rdE) || (branchD && wrEnE && rdE) || (branchD && memToRegM && rdM);
  endfunction

  task automatic clearIn();
    {srcAD, srcBD, srcAE, srcBE, dstE, dstM, dstW} = '0;
    {wrEnE, wrEnM, wrEnW, memToRegE, memToRegM, branchD, intReq} = '0;
  endtask

  task automatic checkAll(input string tag);
    logic s;
    @(negedge clk);
    #1;
    s = expStall();
    applied++;
    if (fwdAE !== expFwdE(srcAE) || fwdBE !== expFwdE(srcBE)) begin
      bad++;
      $display("FAIL %s R1,R2,R3 fwdE got %b/%b exp %b/%b", tag, fwdAE, fwdBE,
               expFwdE(srcAE), expFwdE(srcBE));
    end
    if (fwdAD !== expFwdD(srcAD) || fwdBD !== expFwdD(srcBD)) begin
      bad++;
      $display("FAIL %s R4 fwdD got %b%b exp %b%b", tag, fwdAD, fwdBD,
               expFwdD(srcAD), expFwdD(srcBD));
    end
    if (stallF !== s || stallD !== s || flushE !== (s | intReq)) begin
      bad++;
      $display("FAIL %s R5,R6,R7,R8,R10 stallF/stallD/flushE got %b%b%b exp %b%b%b", tag,
               stallF, stallD, flushE, s, s, s | intReq);
    end
    if (flushD !== intReq) begin
      bad++;
      $display("FAIL %s R9 flushD got %b exp %b", tag, flushD, intReq);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    clearIn();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    checkAll("reset idle R10");

    // R1: memory wins over writeback on same register
    clearIn(); srcAE = 5'd7; srcBE = 5'd7; dstM = 5'd7; dstW = 5'd7; wrEnM = 1; wrEnW = 1;
    checkAll("R1 priority");
    // R2: writeback only
    clearIn(); srcAE = 5'd9; dstW = 5'd9; wrEnW = 1; dstM = 5'd9;
    checkAll("R2 wb only");
    // R3: register zero never forwarded
    clearIn(); dstM = 0; dstW = 0; wrEnM = 1; wrEnW = 1;
    checkAll("R3 zero");
    // R4: decode compare forward
    clearIn(); srcAD = 5'd3; srcBD = 5'd4; dstM = 5'd4; wrEnM = 1;
    checkAll("R4 decode fwd");
    // R5: load-use
    clearIn(); srcBD = 5'd12; dstE = 5'd12; memToRegE = 1; wrEnE = 1;
    checkAll("R5 load use");
    // R6: branch on ALU result in execute
    clearIn(); branchD = 1; srcAD = 5'd5; dstE = 5'd5; wrEnE = 1;
    checkAll("R6 branch alu");
    // R7: branch on load in memory
    clearIn(); branchD = 1; srcBD = 5'd6; dstM = 5'd6; memToRegM = 1; wrEnM = 1;
    checkAll("R7 branch load");
    // R8: no branch, ALU in execute, load in memory
    clearIn(); srcAD = 5'd6; dstE = 5'd6; wrEnE = 1; dstM = 5'd6; memToRegM = 1; wrEnM = 1;
    checkAll("R8 no branch");
    // R8: load to register zero
    clearIn(); memToRegE = 1; wrEnE = 1; branchD = 1;
    checkAll("R8 zero load");
    // R9: interrupt alone and with stall
    clearIn(); intReq = 1;
    checkAll("R9 interrupt");
    srcAD = 5'd2; dstE = 5'd2; memToRegE = 1; wrEnE = 1;
    checkAll("R9 interrupt with stall");

    for (int i = 0; i < 3000; i++) begin
      srcAD = 5'($urandom_range(0, 3)); srcBD = 5'($urandom_range(0, 3));
      srcAE = 5'($urandom_range(0, 3)); srcBE = 5'($urandom_range(0, 3));
      dstE  = 5'($urandom_range(0, 3)); dstM  = 5'($urandom_range(0, 3));
      dstW  = 5'($urandom_range(0, 3));
      wrEnE = 1'($urandom); wrEnM = 1'($urandom); wrEnW = 1'($urandom);
      memToRegE = 1'($urandom); memToRegM = 1'($urandom);
      branchD = 1'($urandom); intReq = ($urandom_range(0, 7) == 0);
      checkAll("random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R10 got timeout exp completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule